// File: doc/BRIEF.md
# Prioritized Interrupt and Fault Controller

The block holds a 16-level pending register, a mask register and a global enable bit. It raises a single request line whenever an eligible level is pending, and it presents the number of the most urgent eligible level as a 4-bit vector. Level 0 is the most urgent and level 15 the least. When the processor acknowledges an interrupt with a vector-read strobe, the pending bit of the level being serviced is dropped.

Pending bits are set from four sources:
- nine active-low user pins, each of which posts on a falling edge only;
- a level-set port for on-chip sources, by convention the first timer's overflow on level 7 and the second timer's on level 9;
- a software set strobe;
- an 8-bit fault register.

The fault register gathers active-low fault lines and posts the machine-error level (1) once. It does not post again until software empties the register with a read-and-clear strobe. This keeps a fault that stays present from flooding the processor with repeated machine-error interrupts.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst_n` is low, the pending, mask and fault registers are cleared and the global enable is off. As a result, `irq_req` is low and `vec` is 0.
- R2: `vec` carries the lowest-numbered level that is eligible. A level is eligible when it is pending, not masked, and not blocked by the global enable. Level 0 outranks level 15.
- R3: A mask bit set to 1 unmasks its level. Levels 0 and 5 are serviced whatever their mask bit. Every other level needs its mask bit set to 1.
- R4: `irq_req` is high exactly when at least one level is eligible. With the enable off, only levels 0, 1 and 5 can be eligible, and level 1 still obeys its mask bit.
- R5: A `vec_rd` pulse while `irq_req` is high clears the pending bit numbered `vec` at the next clock edge. `irq_req` then falls if no other level is eligible.
- R6: User pin i (active low) sets pending level 2, 8, 10, 11, 13, 15, 12, 14 or 3, for i = 0 to 8 in that order. The level is set two clock edges after the pin is first seen low. A pin held low posts once and must go high before it can post again.
- R7: Bit k of `lvl_set` sets pending level k at the next clock edge.
- R8: Fault line j (active low) sets `flt_q[j]` two edges after it is first seen low. The first captured fault sets pending level 1 on that same edge.
- R9: Once level 1 has been posted by a fault, further or standing faults do not post it again while `flt_q` is non-zero.
- R10: Watching `flt_q` leaves it unchanged. A `flt_rd_clr` pulse empties it at the next edge and re-arms posting, so a later fault posts level 1 again.
- R11: On `pend_set_wr` the pending register gains the 1 bits of `reg_wdata`. On `pend_clr_wr` it loses them. On `mask_wr` the mask register is loaded from `reg_wdata`. `en_set` and `en_clr` turn the global enable on and off. If a bit is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_irq_n | input | 9 | Active-low user interrupt pins |
| flt_n | input | 8 | Active-low fault lines |
| lvl_set | input | 16 | One-cycle level-set pulses from internal sources |
| vec_rd | input | 1 | Vector-read (acknowledge) strobe |
| reg_wdata | input | 16 | Write data for mask and pending strobes |
| mask_wr | input | 1 | Load mask register |
| pend_set_wr | input | 1 | OR write data into pending register |
| pend_clr_wr | input | 1 | Clear pending bits given by write data |
| en_set | input | 1 | Turn global enable on |
| en_clr | input | 1 | Turn global enable off |
| flt_rd_clr | input | 1 | Read-and-clear of fault register |
| irq_req | output | 1 | Interrupt request |
| vec | output | 4 | Highest-priority eligible level |
| pend_q | output | 16 | Pending register |
| mask_q | output | 16 | Mask register |
| en_q | output | 1 | Global enable state |
| flt_q | output | 8 | Fault register |

## Verification
The hardest state to reach is a fault line that stays low after its machine-error interrupt has already been acknowledged. In that state the fault register is full while the pending bit is empty, and a single new fault on another line must still not post again. The bench reaches it by holding one fault low, consuming level 1 with a vector read, and then lowering a second fault line. It then releases both lines, issues the read-and-clear, and injects a fresh fault to prove that posting has been re-armed. A user pin held low across a software clear of its pending bit is driven in the same way, so that only the absence of a second edge can keep the bit clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned LVL_W  = 4;
  localparam int unsigned N_LVL  = 1 << LVL_W;
  localparam int unsigned N_USER = 9;
  localparam int unsigned N_FLT  = 8;

  // Levels that ignore the mask bit
  localparam logic [N_LVL-1:0] LVL_NOMASK = N_LVL'(1) | (N_LVL'(1) << 5);
  // Levels that ignore the global enable
  localparam logic [N_LVL-1:0] LVL_NODIS  = LVL_NOMASK | (N_LVL'(1) << 1);
  // Machine-error level posted by the fault register
  localparam int unsigned LVL_MERR = 1;

  // Pending level driven by each user pin
  function automatic int unsigned usr_level(input int unsigned pin);
    case (pin)
      0: usr_level = 2;
      1: usr_level = 8;
      2: usr_level = 10;
      3: usr_level = 11;
      4: usr_level = 13;
      5: usr_level = 15;
      6: usr_level = 12;
      7: usr_level = 14;
      default: usr_level = 3;
    endcase
  endfunction
endpackage

// File: rtl/irq_fall_det.sv
module irq_fall_det #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_n,
  output logic [W-1:0] fall
);
  logic [W-1:0] smp_q;
  logic [W-1:0] old_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic smp_d;
    logic old_d;

    always_comb begin
      smp_d = pin_n[i];
      old_d = smp_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q[i] <= 1'b1;
        old_q[i] <= 1'b1;
      end else begin
        smp_q[i] <= smp_d;
        old_q[i] <= old_d;
      end
    end

    assign fall[i] = old_q[i] & ~smp_q[i];

    AST_ONE_EDGE_PER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      fall[i] |=> !fall[i]); // R6
  end
endmodule

// File: rtl/irq_fault_reg.sv
module irq_fault_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flt_n,
  input  logic         rd_clr,
  output logic [W-1:0] flt_q,
  output logic         post
);
  logic [W-1:0] cap_q;
  logic [W-1:0] cap_d;
  logic [W-1:0] flt_d;
  logic         armed_q;
  logic         armed_d;

  always_comb begin
    cap_d   = ~flt_n;
    post    = (|cap_q) & armed_q & ~rd_clr;
    if (rd_clr) begin
      flt_d   = '0;
      armed_d = 1'b1;
    end else begin
      flt_d   = flt_q | cap_q;
      armed_d = armed_q & ~post;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      flt_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      cap_q   <= cap_d;
      flt_q   <= flt_d;
      armed_q <= armed_d;
    end
  end

  AST_FLT_SINGLE_POST: assert property (@(posedge clk) disable iff (!rst_n)
    (|flt_q) |-> !post); // R9
  AST_FLT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (flt_q == $past(cap_q) || flt_q == '0)); // R10
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned LVL_W = 4,
  localparam int unsigned N = 1 << LVL_W
) (
  input  logic [N-1:0]     req,
  output logic [LVL_W-1:0] vec,
  output logic             any
);
  always_comb begin
    vec = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        vec = LVL_W'(i);
        any = 1'b1;
      end
    end
  end

  AST_VEC_IS_HIGHEST: assert final (!any ||
    (req[vec] && ((req & ((N'(1) << vec) - N'(1))) == '0))); // R2
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_USER-1:0] usr_irq_n,
  input  logic [N_FLT-1:0]  flt_n,
  input  logic [N_LVL-1:0]  lvl_set,
  input  logic              vec_rd,
  input  logic [N_LVL-1:0]  reg_wdata,
  input  logic              mask_wr,
  input  logic              pend_set_wr,
  input  logic              pend_clr_wr,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              flt_rd_clr,
  output logic              irq_req,
  output logic [LVL_W-1:0]  vec,
  output logic [N_LVL-1:0]  pend_q,
  output logic [N_LVL-1:0]  mask_q,
  output logic              en_q,
  output logic [N_FLT-1:0]  flt_q
);
  logic [N_USER-1:0] usr_fall;
  logic              merr_post;
  logic [N_LVL-1:0]  usr_set;
  logic [N_LVL-1:0]  set_all;
  logic [N_LVL-1:0]  clr_all;
  logic [N_LVL-1:0]  eff;
  logic [N_LVL-1:0]  pend_d;
  logic [N_LVL-1:0]  mask_d;
  logic              en_d;

  irq_fall_det #(.W(N_USER)) u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (usr_irq_n),
    .fall  (usr_fall)
  );

  irq_fault_reg #(.W(N_FLT)) u_flt (
    .clk    (clk),
    .rst_n  (rst_n),
    .flt_n  (flt_n),
    .rd_clr (flt_rd_clr),
    .flt_q  (flt_q),
    .post   (merr_post)
  );

  always_comb begin
    usr_set = '0;
    for (int i = 0; i < N_USER; i++) begin
      usr_set[usr_level(i)] = usr_set[usr_level(i)] | usr_fall[i];
    end
  end

  always_comb begin
    eff = pend_q & (mask_q | LVL_NOMASK) & (en_q ? {N_LVL{1'b1}} : LVL_NODIS);
  end

  irq_prio_enc #(.LVL_W(LVL_W)) u_enc (
    .req (eff),
    .vec (vec),
    .any (irq_req)
  );

  always_comb begin
    set_all = usr_set | lvl_set | (pend_set_wr ? reg_wdata : '0);
    set_all[LVL_MERR] = set_all[LVL_MERR] | merr_post;
    clr_all = pend_clr_wr ? reg_wdata : '0;
    if (vec_rd && irq_req) begin
      clr_all[vec] = 1'b1;
    end
    pend_d = (pend_q & ~clr_all) | set_all;
    mask_d = mask_wr ? reg_wdata : mask_q;
    if (en_set) begin
      en_d = 1'b1;
    end else if (en_clr) begin
      en_d = 1'b0;
    end else begin
      en_d = en_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      en_q   <= en_d;
    end
  end

  AST_REQ_DISABLED_ONLY_NODIS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !en_q) |-> |(pend_q & LVL_NODIS)); // R4
  AST_NO_PEND_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !irq_req); // R4
  AST_VECRD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && irq_req && !set_all[vec]) |=> !pend_q[$past(vec)]); // R5
  AST_MASKED_NOT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (mask_q[vec] || LVL_NOMASK[vec])); // R3
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask_q == $past(reg_wdata)); // R11
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [8:0]  usr_irq_n;
  logic [7:0]  flt_n;
  logic [15:0] lvl_set;
  logic        vec_rd;
  logic [15:0] reg_wdata;
  logic        mask_wr, pend_set_wr, pend_clr_wr, en_set, en_clr, flt_rd_clr;
  logic        irq_req;
  logic [3:0]  vec;
  logic [15:0] pend_q, mask_q;
  logic        en_q;
  logic [7:0]  flt_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .usr_irq_n(usr_irq_n), .flt_n(flt_n),
    .lvl_set(lvl_set), .vec_rd(vec_rd), .reg_wdata(reg_wdata),
    .mask_wr(mask_wr), .pend_set_wr(pend_set_wr), .pend_clr_wr(pend_clr_wr),
    .en_set(en_set), .en_clr(en_clr), .flt_rd_clr(flt_rd_clr),
    .irq_req(irq_req), .vec(vec), .pend_q(pend_q), .mask_q(mask_q),
    .en_q(en_q), .flt_q(flt_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_strobe(input int kind, input logic [15:0] d);
    reg_wdata = d;
    case (kind)
      0: mask_wr = 1'b1;
      1: pend_set_wr = 1'b1;
      2: pend_clr_wr = 1'b1;
      3: en_set = 1'b1;
      default: en_clr = 1'b1;
    endcase
    step(1);
    {mask_wr, pend_set_wr, pend_clr_wr, en_set, en_clr} = '0;
  endtask

  task automatic pulse_lvl(input logic [15:0] d);
    lvl_set = d;
    step(1);
    lvl_set = '0;
  endtask

  task automatic read_vec();
    vec_rd = 1'b1;
    step(1);
    vec_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pend", pend_q, 0);
    chk("R1 mask", mask_q, 0);
    chk("R1 en", en_q, 0);
    chk("R1 flt", flt_q, 0);
    chk("R1 irq", irq_req, 0);
    chk("R1 vec", vec, 0);
  endtask

  task automatic t_priority();
    wr_strobe(0, 16'hFFFF);
    wr_strobe(3, 0);
    pulse_lvl(16'h1210);                 // R7: levels 4, 9, 12
    chk("R7 pend", pend_q, 16'h1210);
    chk("R2 irq", irq_req, 1);
    chk("R2 vec", vec, 4);
    read_vec();
    chk("R5 pend after read", pend_q, 16'h1200);
    chk("R2 next vec", vec, 9);
    read_vec();
    chk("R5 vec 12", vec, 12);
    read_vec();
    chk("R5 irq drops", irq_req, 0);
    chk("R5 pend empty", pend_q, 0);
  endtask

  task automatic t_mask();
    wr_strobe(0, 16'h0000);
    pulse_lvl(16'h0008);
    chk("R3 masked lvl3 irq", irq_req, 0);
    pulse_lvl(16'h0020);
    chk("R3 lvl5 unmaskable irq", irq_req, 1);
    chk("R3 lvl5 vec", vec, 5);
    chk("R11 pend kept", pend_q, 16'h0028);
    wr_strobe(2, 16'hFFFF);
    chk("R11 pend clr", pend_q, 0);
    pulse_lvl(16'h0001);
    chk("R3 lvl0 unmaskable vec", {irq_req, vec}, 5'h10);
    wr_strobe(2, 16'h0001);
  endtask

  task automatic t_enable();
    wr_strobe(4, 0);
    wr_strobe(0, 16'hFFFF);
    chk("R11 en off", en_q, 0);
    pulse_lvl(16'h0004);
    chk("R4 disabled lvl2", irq_req, 0);
    pulse_lvl(16'h0002);
    chk("R4 lvl1 bypass enable", {irq_req, vec}, 5'h11);
    wr_strobe(0, 16'hFFFD);
    chk("R4 lvl1 still maskable", irq_req, 0);
    wr_strobe(3, 0);
    chk("R4 enabled lvl2", {irq_req, vec}, 5'h12);
    wr_strobe(2, 16'hFFFF);
    wr_strobe(0, 16'hFFFF);
  endtask

  task automatic t_user();
    usr_irq_n[1] = 1'b0;
    step(2);
    chk("R6 pin1 -> lvl8", pend_q, 16'h0100);
    wr_strobe(2, 16'h0100);
    step(4);
    chk("R6 held low no repost", pend_q, 0);
    usr_irq_n[1] = 1'b1;
    step(2);
    usr_irq_n[1] = 1'b0;
    step(2);
    chk("R6 repost after high", pend_q, 16'h0100);
    usr_irq_n[1] = 1'b1;
    usr_irq_n[8] = 1'b0;
    step(2);
    chk("R6 pin8 -> lvl3", pend_q, 16'h0108);
    usr_irq_n[8] = 1'b1;
    wr_strobe(2, 16'hFFFF);
  endtask

  task automatic t_fault();
    flt_n[2] = 1'b0;
    step(2);
    chk("R8 flt captured", flt_q, 8'h04);
    chk("R8 lvl1 posted", pend_q, 16'h0002);
    chk("R8 vec", vec, 1);
    read_vec();
    chk("R5 lvl1 cleared", pend_q, 0);
    step(3);
    chk("R9 standing fault no repost", pend_q, 0);
    flt_n[6] = 1'b0;
    step(3);
    chk("R9 second fault captured", flt_q, 8'h44);
    chk("R9 second fault no repost", pend_q, 0);
    chk("R10 read keeps flt", flt_q, 8'h44);
    flt_n = 8'hFF;
    step(2);
    flt_rd_clr = 1'b1;
    step(1);
    flt_rd_clr = 1'b0;
    chk("R10 flt cleared", flt_q, 0);
    flt_n[0] = 1'b0;
    step(2);
    flt_n[0] = 1'b1;
    chk("R10 rearmed post", pend_q, 16'h0002);
    chk("R10 rearmed flt", flt_q, 8'h01);
  endtask

  task automatic t_same_cycle();
    reg_wdata   = 16'h0400;
    pend_clr_wr = 1'b1;
    lvl_set     = 16'h0400;
    step(1);
    pend_clr_wr = 1'b0;
    lvl_set     = '0;
    chk("R11 set wins over clear", pend_q[10], 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    usr_irq_n = '1;
    flt_n = '1;
    lvl_set = '0;
    vec_rd = 1'b0;
    reg_wdata = '0;
    {mask_wr, pend_set_wr, pend_clr_wr, en_set, en_clr, flt_rd_clr} = '0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_priority();
    t_mask();
    t_enable();
    t_user();
    t_fault();
    t_same_cycle();
    finish_run();
  end
endmodule